// File: doc/BRIEF.md
# Pipelined CRT Residue-to-Binary Converter

This block turns a residue-coded integer back into ordinary binary. With the triple moduli set {2^m−1, 2^m+1, 2^(2m)+1} it accepts three residues and returns the unique integer in [0, 2^(4m)−1). With the pair set {2^m−1, 2^m+1} it accepts two residues and returns the integer in [0, 2^(2m)−1). The `THREE_MOD` parameter picks the set at elaboration time.

The triple path evaluates the Chinese Remainder Theorem sum modulo 2^(4m)−1. Every product of a residue with a CRT weight and its inverse becomes a fixed rotation of a 4m-bit word. Positive and negative weight parts are kept apart as a signed-digit pair of carry-save vectors, so the first stage has no carry chain. The second stage folds that signed-digit form into two binary operands, using one's complement for the negative half. The third stage is a single end-around-carry add, which also maps the all-ones alias of zero to zero.

The pair path uses the same three stages on m-bit words to form |2^(m−1)(x1−x2)| mod (2^m−1). A fourth register then adds x2. One input set can enter on every cycle. Results leave in input order, after a fixed latency, with a valid strobe.

Top module: `crt_r2b`

## Requirements
- R1: With THREE_MOD=1, out_value is the unique X in [0, 2^(4m)−2] with X mod (2^m−1) = res_a, X mod (2^m+1) = res_b and X mod (2^(2m)+1) = res_c.
- R2: With THREE_MOD=0, out_value is the unique X in [0, 2^(2m)−2] with X mod (2^m−1) = res_a and X mod (2^m+1) = res_b. The upper 2m bits of out_value are zero.
- R3: out_valid is high exactly once for each accepted input (in_valid high at a rising edge). It is high 3 cycles after acceptance with THREE_MOD=1 and 4 cycles after acceptance with THREE_MOD=0.
- R4: The top residue values are legal and are treated as −1: res_b = 2^m and res_c = 2^(2m). The legal input ranges are res_a ≤ 2^m−1, res_b ≤ 2^m and res_c ≤ 2^(2m).
- R5: The result is canonical. The all-ones pattern 2^(4m)−1 never appears on a valid output with THREE_MOD=1. res_a = 2^m−1 is accepted as an alias of residue 0.
- R6: With THREE_MOD=0, res_c has no effect on any output.
- R7: A synchronous active-high rst clears out_valid and out_value to 0.
- R8: A new input may be accepted on every cycle. Results appear in acceptance order and none is lost or duplicated.
- R9: out_value holds its last result while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Residue set present this cycle |
| res_a | input | M_BITS | Residue modulo 2^m−1 |
| res_b | input | M_BITS+1 | Residue modulo 2^m+1 |
| res_c | input | 2*M_BITS+1 | Residue modulo 2^(2m)+1 (triple set only) |
| out_valid | output | 1 | Result present on out_value |
| out_value | output | 4*M_BITS | Binary result |

## Verification
Two things can happen in the same cycle: a finished result is loaded into the output register while a fresh residue set is captured by the signed-digit stage. Every residue combination for m=3 (triple set) and m=4 (pair set) is streamed back to back to provoke this. A seeded random run then adds bubbles in in_valid, and for the pair set random res_c values. Each output is judged against an in-order queue of expected values. Those values come from a table built by walking every integer in the dynamic range and recording its residues. The final queue count must match exactly, and a single isolated input measures the latency and the holding of the result.

// File: rtl/crt_r2b_pkg.sv
package crt_r2b_pkg;

  // pipeline depth from accepted input to out_valid
  function automatic int latency_of(input int three_mod);
    return (three_mod != 0) ? 3 : 4;
  endfunction

  // number of positive / negative rotated words for the triple set
  localparam int TRIPLE_NPOS = 7;
  localparam int TRIPLE_NNEG = 3;
  localparam int PAIR_NPOS   = 1;
  localparam int PAIR_NNEG   = 2;

endpackage

// File: rtl/crt_sd_accum.sv
// Stage 1: carry-free signed-digit accumulation of rotated CRT words.
// Positive and negative words are reduced separately by end-around
// carry-save cells, giving a signed-digit pair (ps+pc) - (ns+nc) mod 2^W-1.
module crt_sd_accum #(
  parameter int W  = 32,
  parameter int NP = 7,
  parameter int NN = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] pos_w [NP],
  input  logic [W-1:0] neg_w [NN],
  output logic         vld_q,
  output logic [W-1:0] ps_q,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] ns_q,
  output logic [W-1:0] nc_q
);

  // 3:2 compressor with the carry vector rotated (2*c mod 2^W-1)
  function automatic logic [2*W-1:0] csa_eac(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic [W-1:0] c);
    logic [W-1:0] s;
    logic [W-1:0] cy;
    s  = a ^ b ^ c;
    cy = (a & b) | (a & c) | (b & c);
    return {s, cy[W-2:0], cy[W-1]};
  endfunction

  logic [W-1:0] p_s, p_c, n_s, n_c;

  always_comb begin
    p_s = pos_w[0];
    p_c = '0;
    for (int i = 1; i < NP; i++) begin
      {p_s, p_c} = csa_eac(p_s, p_c, pos_w[i]);
    end
    n_s = neg_w[0];
    n_c = '0;
    for (int i = 1; i < NN; i++) begin
      {n_s, n_c} = csa_eac(n_s, n_c, neg_w[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ps_q  <= '0;
      pc_q  <= '0;
      ns_q  <= '0;
      nc_q  <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        ps_q <= p_s;
        pc_q <= p_c;
        ns_q <= n_s;
        nc_q <= n_c;
      end
    end
  end

  // ---- checking: value modulo 2^W-1 must survive the reduction ----
  function automatic logic [W-1:0] mod_add(input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[W-1:0] + {{(W-1){1'b0}}, t[W]};
  endfunction

  function automatic logic [W-1:0] canon_f(input logic [W-1:0] v);
    return (&v) ? '0 : v;
  endfunction

  logic [W-1:0] in_mod, reg_mod;

  always_comb begin
    in_mod = '0;
    for (int i = 0; i < NP; i++) in_mod = mod_add(in_mod, pos_w[i]);
    for (int i = 0; i < NN; i++) in_mod = mod_add(in_mod, ~neg_w[i]);
    reg_mod = mod_add(mod_add(ps_q, pc_q), mod_add(~ns_q, ~nc_q));
  end

  AST_SD_SUM: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> canon_f(reg_mod) == canon_f($past(in_mod)));  // R1

endmodule

// File: rtl/crt_sd_to_bin.sv
// Stage 2: signed-digit pair folded into two binary operands. The negative
// half enters as one's complement, which is negation modulo 2^W-1.
module crt_sd_to_bin #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] ps,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] ns,
  input  logic [W-1:0] nc,
  output logic         vld_q,
  output logic [W-1:0] op_a_q,
  output logic [W-1:0] op_b_q
);

  logic [W-1:0] s1, c1, s2, c2, cy1, cy2;

  always_comb begin
    s1  = ps ^ pc ^ ~ns;
    cy1 = (ps & pc) | (ps & ~ns) | (pc & ~ns);
    c1  = {cy1[W-2:0], cy1[W-1]};
    s2  = s1 ^ c1 ^ ~nc;
    cy2 = (s1 & c1) | (s1 & ~nc) | (c1 & ~nc);
    c2  = {cy2[W-2:0], cy2[W-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      op_a_q <= '0;
      op_b_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        op_a_q <= s2;
        op_b_q <= c2;
      end
    end
  end

endmodule

// File: rtl/crt_eac_add.sv
// Stage 3: end-around-carry addition modulo 2^W-1 with the all-ones
// alias of zero mapped to zero.
module crt_eac_add #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         vld_q,
  output logic [W-1:0] res_q
);

  logic [W:0]   raw_sum;
  logic [W-1:0] wrapped, canon;

  always_comb begin
    raw_sum = {1'b0, op_a} + {1'b0, op_b};
    wrapped = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};
    canon   = (&wrapped) ? '0 : wrapped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) res_q <= canon;
    end
  end

  AST_CANON: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> !(&res_q));  // R5

endmodule

// File: rtl/crt_r2b.sv
module crt_r2b
  import crt_r2b_pkg::*;
#(
  parameter int M_BITS    = 8,
  parameter int THREE_MOD = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [M_BITS-1:0]     res_a,
  input  logic [M_BITS:0]       res_b,
  input  logic [2*M_BITS:0]     res_c,
  output logic                  out_valid,
  output logic [4*M_BITS-1:0]   out_value
);

  localparam int WT  = 4 * M_BITS;
  localparam int WN  = M_BITS;
  localparam int LAT = latency_of(THREE_MOD);

  // multiply by 2^k modulo 2^WT-1
  function automatic logic [WT-1:0] rot_t(input logic [WT-1:0] v, input int k);
    return (v << k) | (v >> (WT - k));
  endfunction

  // multiply by 2^k modulo 2^WN-1
  function automatic logic [WN-1:0] rot_n(input logic [WN-1:0] v, input int k);
    return (v << k) | (v >> (WN - k));
  endfunction

  if (THREE_MOD != 0) begin : g_triple
    logic [WT-1:0] pw [TRIPLE_NPOS];
    logic [WT-1:0] nw [TRIPLE_NNEG];
    logic [WT-1:0] a_z, b_z, c_z;
    logic          v1, v2, v3;
    logic [WT-1:0] ps, pc, ns, nc, oa, ob, res;

    always_comb begin
      a_z = {{(WT-M_BITS){1'b0}}, res_a};
      b_z = {{(WT-M_BITS-1){1'b0}}, res_b};
      c_z = {{(WT-2*M_BITS-1){1'b0}}, res_c};
      // a * 2^(m-2) * (1 + 2^m + 2^2m + 2^3m)
      pw[0] = rot_t(a_z, M_BITS - 2);
      pw[1] = rot_t(a_z, 2*M_BITS - 2);
      pw[2] = rot_t(a_z, 3*M_BITS - 2);
      pw[3] = rot_t(a_z, 4*M_BITS - 2);
      // b * 2^(m-2) * (2^3m + 2^m - 2^2m - 1)
      pw[4] = rot_t(b_z, 4*M_BITS - 2);
      pw[5] = rot_t(b_z, 2*M_BITS - 2);
      nw[0] = rot_t(b_z, 3*M_BITS - 2);
      nw[1] = rot_t(b_z, M_BITS - 2);
      // c * 2^(2m-1) * (2^2m - 1)
      pw[6] = rot_t(c_z, 4*M_BITS - 1);
      nw[2] = rot_t(c_z, 2*M_BITS - 1);
    end

    crt_sd_accum #(.W(WT), .NP(TRIPLE_NPOS), .NN(TRIPLE_NNEG)) i_accum (
      .clk(clk), .rst(rst), .in_vld(in_valid), .pos_w(pw), .neg_w(nw),
      .vld_q(v1), .ps_q(ps), .pc_q(pc), .ns_q(ns), .nc_q(nc));

    crt_sd_to_bin #(.W(WT)) i_to_bin (
      .clk(clk), .rst(rst), .in_vld(v1), .ps(ps), .pc(pc), .ns(ns), .nc(nc),
      .vld_q(v2), .op_a_q(oa), .op_b_q(ob));

    crt_eac_add #(.W(WT)) i_eac (
      .clk(clk), .rst(rst), .in_vld(v2), .op_a(oa), .op_b(ob),
      .vld_q(v3), .res_q(res));

    assign out_valid = v3;
    assign out_value = res;

    AST_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_value != {WT{1'b1}});  // R5
  end else begin : g_pair
    logic [WN-1:0] pw [PAIR_NPOS];
    logic [WN-1:0] nw [PAIR_NNEG];
    logic          v1, v2, v3, v4;
    logic [WN-1:0] ps, pc, ns, nc, oa, ob, y;
    logic [M_BITS:0] b_d1, b_d2, b_d3;
    logic [2*M_BITS-1:0] fin_sum;
    logic [WT-1:0]   out_q;

    always_comb begin
      // 2^(m-1) * (a - b) modulo 2^m-1, with b folded as lo + top
      pw[0] = rot_n(res_a, M_BITS - 1);
      nw[0] = rot_n(res_b[M_BITS-1:0], M_BITS - 1);
      nw[1] = rot_n({{(M_BITS-1){1'b0}}, res_b[M_BITS]}, M_BITS - 1);
    end

    crt_sd_accum #(.W(WN), .NP(PAIR_NPOS), .NN(PAIR_NNEG)) i_accum (
      .clk(clk), .rst(rst), .in_vld(in_valid), .pos_w(pw), .neg_w(nw),
      .vld_q(v1), .ps_q(ps), .pc_q(pc), .ns_q(ns), .nc_q(nc));

    crt_sd_to_bin #(.W(WN)) i_to_bin (
      .clk(clk), .rst(rst), .in_vld(v1), .ps(ps), .pc(pc), .ns(ns), .nc(nc),
      .vld_q(v2), .op_a_q(oa), .op_b_q(ob));

    crt_eac_add #(.W(WN)) i_eac (
      .clk(clk), .rst(rst), .in_vld(v2), .op_a(oa), .op_b(ob),
      .vld_q(v3), .res_q(y));

    // b travels beside the three stages, loaded by the same strobes
    always_ff @(posedge clk) begin
      if (rst) begin
        b_d1 <= '0;
        b_d2 <= '0;
        b_d3 <= '0;
      end else begin
        if (in_valid) b_d1 <= res_b;
        if (v1)       b_d2 <= b_d1;
        if (v2)       b_d3 <= b_d2;
      end
    end

    // x = b + (2^m + 1) * y, never exceeds 2^2m - 2
    assign fin_sum = {{(M_BITS-1){1'b0}}, b_d3} + {y, y};

    always_ff @(posedge clk) begin
      if (rst) begin
        v4    <= 1'b0;
        out_q <= '0;
      end else begin
        v4 <= v3;
        if (v3) out_q <= {{(WT-2*M_BITS){1'b0}}, fin_sum};
      end
    end

    assign out_valid = v4;
    assign out_value = out_q;

    AST_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_value <= (WT'(1) << (2*M_BITS)) - WT'(2));  // R2
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##LAT out_valid);  // R3
  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##LAT !out_valid);  // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_value));  // R9
  AST_IN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (res_b <= ((M_BITS+1)'(1) << M_BITS)) &&
                 (THREE_MOD == 0 || res_c <= ((2*M_BITS+1)'(1) << (2*M_BITS))));  // R4

endmodule

// File: tb/test_crt_r2b.sv
`timescale 1ns/1ps
module test_crt_r2b;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // triple set, m = 3
  logic        t_iv = 1'b0;
  logic [2:0]  t_a = '0;
  logic [3:0]  t_b = '0;
  logic [6:0]  t_c = '0;
  logic        t_ov;
  logic [11:0] t_out;

  // pair set, m = 4
  logic        p_iv = 1'b0;
  logic [3:0]  p_a = '0;
  logic [4:0]  p_b = '0;
  logic [8:0]  p_c = '0;
  logic        p_ov;
  logic [15:0] p_out;

  crt_r2b #(.M_BITS(3), .THREE_MOD(1)) i_crt_r2b (
    .clk(clk), .rst(rst), .in_valid(t_iv), .res_a(t_a), .res_b(t_b),
    .res_c(t_c), .out_valid(t_ov), .out_value(t_out));

  crt_r2b #(.M_BITS(4), .THREE_MOD(0)) i_crt_r2b_pair (
    .clk(clk), .rst(rst), .in_valid(p_iv), .res_a(p_a), .res_b(p_b),
    .res_c(p_c), .out_valid(p_ov), .out_value(p_out));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int ref3 [0:6][0:8][0:64];
  int ref2 [0:14][0:16];
  int exp3 [0:16383];
  int exp2 [0:16383];
  int wr3 = 0, rd3 = 0, wr2 = 0, rd2 = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int want3(input int a, input int b, input int c);
    return ref3[a % 7][b % 9][c % 65];
  endfunction

  function automatic int want2(input int a, input int b);
    return ref2[a % 15][b % 17];
  endfunction

  // in-order output monitors (R1, R2, R6, R8)
  always @(negedge clk) begin
    if (!rst && t_ov) begin
      if (rd3 < wr3) chk(int'(t_out) == exp3[rd3], "R1 R8 triple result", t_out, exp3[rd3]);
      else           chk(1'b0, "R8 triple unexpected output", t_out, -1);
      rd3++;
    end
    if (!rst && p_ov) begin
      if (rd2 < wr2) chk(int'(p_out) == exp2[rd2], "R2 R6 R8 pair result", p_out, exp2[rd2]);
      else           chk(1'b0, "R8 pair unexpected output", p_out, -1);
      rd2++;
    end
  end

  task automatic put3(input int a, input int b, input int c);
    t_a = 3'(a); t_b = 4'(b); t_c = 7'(c); t_iv = 1'b1;
    exp3[wr3] = want3(a, b, c);
    wr3++;
  endtask

  task automatic put2(input int a, input int b, input int c);
    p_a = 4'(a); p_b = 5'(b); p_c = 9'(c); p_iv = 1'b1;
    exp2[wr2] = want2(a, b);
    wr2++;
  endtask

  task automatic idle(input int n);
    t_iv = 1'b0; p_iv = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic single3(input int a, input int b, input int c, input int e, input string tag);
    put3(a, b, c);
    @(negedge clk); t_iv = 1'b0;
    repeat (2) @(negedge clk);
    chk(t_ov == 1'b1 && int'(t_out) == e, tag, t_out, e);
    idle(2);
  endtask

  task automatic single2(input int a, input int b, input int c, input int e, input string tag);
    put2(a, b, c);
    @(negedge clk); p_iv = 1'b0;
    repeat (3) @(negedge clk);
    chk(p_ov == 1'b1 && int'(p_out) == e, tag, p_out, e);
    idle(2);
  endtask

  initial begin
    int seed_v;
    int hold3, hold2;
    seed_v = $urandom(32'd7151);
    for (int x = 0; x < 4095; x++) ref3[x % 7][x % 9][x % 65] = x;
    for (int x = 0; x < 255; x++)  ref2[x % 15][x % 17] = x;

    repeat (4) @(negedge clk);
    chk(t_ov == 1'b0 && t_out == '0, "R7 triple reset state", t_out, 0);
    chk(p_ov == 1'b0 && p_out == '0, "R7 pair reset state", p_out, 0);
    rst = 1'b0;
    idle(2);

    // latency and hold with one isolated input on each instance
    put3(3, 5, 40);
    put2(9, 11, 300);
    @(negedge clk); t_iv = 1'b0; p_iv = 1'b0;
    chk(t_ov == 1'b0 && p_ov == 1'b0, "R3 no output after 1 cycle", t_ov, 0);
    @(negedge clk);
    chk(t_ov == 1'b0 && p_ov == 1'b0, "R3 no output after 2 cycles", p_ov, 0);
    @(negedge clk);
    chk(t_ov == 1'b1, "R3 triple valid after 3 cycles", t_ov, 1);
    chk(p_ov == 1'b0, "R3 pair idle after 3 cycles", p_ov, 0);
    hold3 = int'(t_out);
    @(negedge clk);
    chk(t_ov == 1'b0, "R3 triple single pulse", t_ov, 0);
    chk(int'(t_out) == hold3, "R9 triple value held", t_out, hold3);
    chk(p_ov == 1'b1, "R3 pair valid after 4 cycles", p_ov, 1);
    hold2 = int'(p_out);
    repeat (3) @(negedge clk);
    chk(p_ov == 1'b0 && int'(p_out) == hold2, "R9 pair value held", p_out, hold2);
    chk(int'(t_out) == hold3, "R9 triple value still held", t_out, hold3);

    // corner residues
    single3(6, 8, 64, 4094, "R4 all residues at -1");
    single3(0, 8, 0, want3(0, 8, 0), "R4 top value of b");
    single3(0, 0, 64, want3(0, 0, 64), "R4 top value of c");
    single3(0, 0, 0, 0, "R5 zero result");
    single3(7, 0, 0, 0, "R5 alias of zero on a");
    single3(7, 8, 64, want3(0, 8, 64), "R5 alias with top values");
    single2(14, 16, 0, 254, "R4 pair all residues at -1");
    single2(15, 0, 0, 0, "R5 pair alias of zero");
    single2(5, 7, 0, want2(5, 7), "R6 pair c zero");
    single2(5, 7, 511, want2(5, 7), "R6 pair c ones");

    // exhaustive, back to back (R1, R8)
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 9; b++)
        for (int c = 0; c < 65; c++) begin
          put3(a, b, c);
          @(negedge clk);
        end
    idle(1);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 17; b++) begin
        put2(a, b, int'($urandom_range(0, 511)));
        @(negedge clk);
      end
    idle(1);

    // seeded random with bubbles on both instances
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(0, 3) != 0)
        put3(int'($urandom_range(0, 7)), int'($urandom_range(0, 8)), int'($urandom_range(0, 64)));
      else t_iv = 1'b0;
      if ($urandom_range(0, 3) != 0)
        put2(int'($urandom_range(0, 15)), int'($urandom_range(0, 16)), int'($urandom_range(0, 511)));
      else p_iv = 1'b0;
      @(negedge clk);
    end
    idle(10);
    chk(rd3 == wr3, "R8 triple output count", rd3, wr3);
    chk(rd2 == wr2, "R8 pair output count", rd2, wr2);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule